// File: doc/BRIEF.md
# Misaligned Access Splitting Bus Sequencer

This block sits between a processor's load/store path and a 32-bit big-endian external bus. It takes one operand request at a time: a byte address, an operand size (byte, word or longword), a direction and, for stores, the operand value. It then plays that operand out as a chain of naturally aligned bus transfers. A request that is already aligned costs one transfer. A misaligned one is cut into pieces, and each piece uses the widest aligned size that fits both the current address and the bytes still left.

For every transfer the sequencer drives the byte address, a size code, the direction and a one-clock start strobe, and then waits for the slave's acknowledge. Store bytes are placed on the data lanes that match each piece's address. Load bytes are collected from the lanes into a right-justified operand. The assembled result comes back as a one-cycle response pulse after the final acknowledge.

An instruction fetch at an odd address never reaches the bus. It produces an address-error pulse instead. The request side is a valid/ready handshake: `req_ready` is high only when idle, so a request waits with `req_valid` held until it is taken. The response pulse and the error pulse cannot be back-pressured. The processor side must accept them in the cycle they appear.

Top module: `masp_bus_seq`

## Requirements
- R1: An aligned request takes exactly one bus transfer of the operand's own size at the request address. A byte is aligned anywhere, a word at an even address, and a longword at a multiple of four.
- R2: A misaligned request becomes consecutive transfers at rising byte addresses. Each transfer uses the largest aligned size that fits the remaining bytes: a longword at offset 1 gives byte, word, byte; at offset 2 it gives word, word; at offset 3 it gives byte, word, byte. A word at an odd address gives two byte transfers, including when it crosses a longword boundary.
- R3: Size codes on `req_size` and `bus_size` are 2'b00 longword, 2'b01 byte and 2'b10 word. A request with code 2'b11 is handled as a longword. `bus_rw` is 1 for a read and 0 for a write.
- R4: Lane order is big-endian. The byte at address offset 0 uses `bus_wdata`/`bus_rdata` bits [31:24], offset 1 uses [23:16], offset 2 uses [15:8] and offset 3 uses [7:0]. On a write, each used lane carries the operand byte for that address, and unused lanes are zero.
- R5: On a read, `rsp_rdata` holds the operand right-justified, with the lowest-addressed byte most significant and the unused upper bytes zero. `rsp_valid` pulses for one cycle, in the cycle after the final acknowledge. `rsp_rdata` holds its value until the next request is accepted. Write responses also pulse `rsp_valid`.
- R6: `bus_ts` is high for exactly one clock at the start of each transfer. `bus_addr` stays stable until the acknowledge. `bus_ta` is recognized only in cycles after the strobe, never during the strobe cycle itself. The next piece's strobe follows in the cycle after an acknowledge.
- R7: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the cycle after the last acknowledge.
- R8: A fetch request (`req_fetch`=1) at an odd address starts no bus transfer. It pulses `fetch_err` for one cycle in the cycle after acceptance, and `req_ready` stays high. A fetch at an even address is served as a read.
- R9: A synchronous active-high `rst` returns the block to idle: `req_ready`=1, `bus_ts`=0, `rsp_valid`=0 and `fetch_err`=0, including when it arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | 32 | Store operand, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled load operand, right-justified |
| fetch_err | output | 1 | One-cycle address-error pulse for an odd fetch |
| bus_addr | output | ADDR_W | Byte address of the current transfer |
| bus_size | output | 2 | Size code of the current transfer |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_ta | input | 1 | Slave transfer acknowledge |
| bus_wdata | output | 32 | Write lanes |
| bus_rdata | input | 32 | Read lanes |

## Verification
The bench builds the block with the default 32-bit address width. This lets random addresses reach the whole space, including a longword at the very top that wraps to address zero in its last piece. The slave model acknowledges after a random delay of one to three cycles, and sometimes raises a spurious acknowledge during the strobe cycle, so that ignoring it can be observed as a correct piece count and correct data. Every request offset and size code, including the reserved code, is covered by both directed and random requests. Expected piece lists, lane words and read results come from bench functions written from the requirements.

// File: rtl/masp_pkg.sv
package masp_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10
  } bsize_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_e;

  // Operand byte count for a request size code; the reserved code counts as a longword.
  function automatic logic [2:0] op_bytes(input logic [1:0] code);
    case (code)
      2'b01:   op_bytes = 3'd1;
      2'b10:   op_bytes = 3'd2;
      default: op_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/masp_piece_plan.sv
module masp_piece_plan
  import masp_pkg::*;
(
  input  logic [1:0] off,
  input  logic [2:0] rem,
  output bsize_e     psize,
  output logic [2:0] pbytes
);
  always_comb begin
    if (off == 2'd0 && rem >= 3'd4) begin
      psize  = SZ_LONG;
      pbytes = 3'd4;
    end else if (!off[0] && rem >= 3'd2) begin
      psize  = SZ_WORD;
      pbytes = 3'd2;
    end else begin
      psize  = SZ_BYTE;
      pbytes = 3'd1;
    end
  end
endmodule

// File: rtl/masp_lane_steer.sv
module masp_lane_steer
  import masp_pkg::*;
(
  input  logic [1:0]    off,
  input  logic [2:0]    pbytes,
  input  logic [1:0]    done_k,
  input  logic [2:0]    op_len,
  input  logic [DW-1:0] wop,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] opreg,
  output logic [DW-1:0] lanes_w,
  output logic [DW-1:0] merged
);
  // Write side: lane L carries the operand byte whose address sits at offset L.
  for (genvar L = 0; L < LANES; L++) begin : g_wlane
    logic       hit;
    logic [1:0] rel, idx, pos;
    logic [7:0] b;
    always_comb begin
      hit = (3'(L) >= {1'b0, off}) && (3'(L) < ({1'b0, off} + pbytes));
      rel = 2'(L) - off;
      idx = done_k + rel;
      pos = op_len[1:0] - 2'd1 - idx;
      b   = hit ? 8'(wop >> {pos, 3'b000}) : 8'h00;
    end
    assign lanes_w[(LANES-1-L)*8 +: 8] = b;
  end

  // Read side: operand byte P (counted from the LSB) takes its lane if this piece covers it.
  for (genvar P = 0; P < LANES; P++) begin : g_rbyte
    logic       hit;
    logic [2:0] idx;
    logic [1:0] lane, sel;
    logic [7:0] b;
    always_comb begin
      idx  = op_len - 3'd1 - 3'(P);
      hit  = (3'(P) < op_len) && (idx >= {1'b0, done_k}) &&
             (idx < ({1'b0, done_k} + pbytes));
      lane = off + idx[1:0] - done_k;
      sel  = 2'd3 - lane;
      b    = hit ? 8'(rdata >> {sel, 3'b000}) : opreg[P*8 +: 8];
    end
    assign merged[P*8 +: 8] = b;
  end
endmodule

// File: rtl/masp_bus_seq.sv
module masp_bus_seq
  import masp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              fetch_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_rw,
  output logic              bus_ts,
  input  logic              bus_ta,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);
  seq_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        rem;
  logic [2:0]        op_len;
  logic [1:0]        done_k;
  logic              is_wr;
  logic [DW-1:0]     wop;
  logic [DW-1:0]     opreg;
  logic              rsp_q, ferr_q;

  bsize_e        psize;
  logic [2:0]    pbytes;
  logic [DW-1:0] lanes_w, merged;

  masp_piece_plan u_plan (
    .off    (cur_addr[1:0]),
    .rem    (rem),
    .psize  (psize),
    .pbytes (pbytes)
  );

  masp_lane_steer u_steer (
    .off     (cur_addr[1:0]),
    .pbytes  (pbytes),
    .done_k  (done_k),
    .op_len  (op_len),
    .wop     (wop),
    .rdata   (bus_rdata),
    .opreg   (opreg),
    .lanes_w (lanes_w),
    .merged  (merged)
  );

  wire accept = (state == ST_IDLE) && req_valid;
  wire acked  = (state == ST_WAIT) && bus_ta;
  wire last   = (rem == pbytes);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      op_len   <= '0;
      done_k   <= '0;
      is_wr    <= 1'b0;
      wop      <= '0;
      opreg    <= '0;
      rsp_q    <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      rsp_q  <= 1'b0;
      ferr_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (req_fetch && req_addr[0]) begin
            ferr_q <= 1'b1;
          end else begin
            cur_addr <= req_addr;
            rem      <= op_bytes(req_size);
            op_len   <= op_bytes(req_size);
            done_k   <= 2'd0;
            is_wr    <= req_write;
            wop      <= req_wdata;
            opreg    <= '0;
            state    <= ST_STROBE;
          end
        end
        ST_STROBE: state <= ST_WAIT;
        ST_WAIT: if (acked) begin
          if (!is_wr) opreg <= merged;
          if (last) begin
            rsp_q <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cur_addr <= cur_addr + ADDR_W'(pbytes);
            rem      <= rem - pbytes;
            done_k   <= done_k + pbytes[1:0];
            state    <= ST_STROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = opreg;
  assign fetch_err = ferr_q;
  assign bus_addr  = cur_addr;
  assign bus_size  = psize;
  assign bus_rw    = !is_wr;
  assign bus_ts    = (state == ST_STROBE);
  assign bus_wdata = (state != ST_IDLE && is_wr) ? lanes_w : '0;

  // R6: the start strobe lasts a single clock
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts);
  // R6: the address holds while waiting for the acknowledge
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> $stable(bus_addr));
  // R7: no new request is taken while a transfer is on the bus
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> !req_ready);
  // R1/R2: every issued piece is naturally aligned for its size
  a_r2_piece_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> !((bus_size == SZ_LONG && bus_addr[1:0] != 2'd0) ||
                 (bus_size == SZ_WORD && bus_addr[0])));
  // R8: an address error leaves the bus untouched and the block idle
  a_r8_fetch_no_cycle: assert property (@(posedge clk) disable iff (rst)
    fetch_err |-> (req_ready && !bus_ts));
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_masp_bus_seq.sv
module tb_masp_bus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        fetch_err;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rw;
  logic        bus_ts;
  logic        bus_ta = 1'b0;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  masp_bus_seq #(.ADDR_W(32)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_fetch(req_fetch), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .fetch_err(fetch_err), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_rw(bus_rw), .bus_ts(bus_ts), .bus_ta(bus_ta),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[3:0], a[11:8]} ^ a[31:24];
  endfunction

  function automatic int nbytes_of(input logic [1:0] code);
    return (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 4;
  endfunction

  // Expected piece list: largest aligned size fitting the remaining bytes.
  logic [31:0] exp_a [4];
  logic [1:0]  exp_s [4];
  int          exp_n;
  task automatic plan(input logic [31:0] a, input int n);
    logic [31:0] cur = a;
    int rem = n;
    exp_n = 0;
    while (rem > 0) begin
      int pn;
      if (cur[1:0] == 2'd0 && rem >= 4) begin pn = 4; exp_s[exp_n] = 2'b00; end
      else if (!cur[0] && rem >= 2)     begin pn = 2; exp_s[exp_n] = 2'b10; end
      else                              begin pn = 1; exp_s[exp_n] = 2'b01; end
      exp_a[exp_n] = cur;
      exp_n++;
      cur = cur + 32'(pn);
      rem = rem - pn;
    end
  endtask

  function automatic logic [31:0] exp_lanes(input logic [31:0] a, input int n,
      input logic [31:0] wd, input logic [31:0] pa, input logic [1:0] ps);
    logic [31:0] r = '0;
    int pn = nbytes_of(ps);
    int off = int'(pa[1:0]);
    for (int l = 0; l < 4; l++) begin
      if (l >= off && l < off + pn) begin
        int idx = int'(pa - a) + (l - off);
        r[(3-l)*8 +: 8] = wd[(n-1-idx)*8 +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] a, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r = (r << 8) | {24'd0, mbyte(a + 32'(k))};
    return r;
  endfunction

  function automatic logic [31:0] slave_lanes(input logic [31:0] pa);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[(3-l)*8 +: 8] = mbyte({pa[31:2], 2'b00} + 32'(l));
    return r;
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                         input bit fe, input logic [31:0] wd, input bit spur_ok);
    logic [31:0] got_a [4];
    logic [1:0]  got_s [4];
    logic        got_rw [4];
    logic [31:0] got_w [4];
    int n = nbytes_of(sz);
    int np = 0;
    int guard = 0;
    bit done = 0;
    plan(a, n);
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_fetch = fe; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (fe && a[0]) begin
      chk(fetch_err == 1'b1, "R8", "odd fetch error pulse", 32'(fetch_err), 32'd1);
      chk(bus_ts == 1'b0, "R8", "odd fetch starts no transfer", 32'(bus_ts), 32'd0);
      chk(req_ready == 1'b1, "R8", "odd fetch ready stays high", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk(fetch_err == 1'b0 && bus_ts == 1'b0, "R8", "error pulse one cycle, still no strobe",
          {30'd0, fetch_err, bus_ts}, 32'd0);
      return;
    end
    while (!done && guard < 200) begin
      guard++;
      if (rsp_valid) begin
        done = 1;
      end else if (bus_ts) begin
        int d = 1 + int'($urandom % 3);
        if (req_ready) chk(0, "R7", "ready low during transfer", 32'(req_ready), 32'd0);
        if (np < 4) begin
          got_a[np] = bus_addr; got_s[np] = bus_size; got_rw[np] = bus_rw; got_w[np] = bus_wdata;
        end
        np++;
        if (spur_ok && ($urandom % 2 == 0)) begin
          bus_rdata = 32'hDEADBEEF; bus_ta = 1'b1;
          @(negedge clk);
          bus_ta = 1'b0;
          if (bus_ts) chk(0, "R6", "strobe longer than one clock", 32'(bus_ts), 32'd0);
          repeat (d - 1) @(negedge clk);
        end else begin
          @(negedge clk);
          if (bus_ts) chk(0, "R6", "strobe longer than one clock", 32'(bus_ts), 32'd0);
          repeat (d - 1) @(negedge clk);
        end
        bus_rdata = slave_lanes(bus_addr);
        bus_ta = 1'b1;
        @(negedge clk);
        bus_ta = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, "R5", "completion pulse seen", 32'(done), 32'd1);
    chk(np == exp_n, "R2", $sformatf("piece count for addr %h size %b", a, sz), 32'(np), 32'(exp_n));
    for (int i = 0; i < exp_n && i < np; i++) begin
      chk(got_a[i] == exp_a[i], "R2", $sformatf("piece %0d address", i), got_a[i], exp_a[i]);
      chk(got_s[i] == exp_s[i], "R3", $sformatf("piece %0d size code", i), 32'(got_s[i]), 32'(exp_s[i]));
      chk(got_rw[i] == !wr, "R3", $sformatf("piece %0d direction", i), 32'(got_rw[i]), 32'(!wr));
      if (wr)
        chk(got_w[i] == exp_lanes(a, n, wd, exp_a[i], exp_s[i]), "R4",
            $sformatf("piece %0d write lanes", i), got_w[i], exp_lanes(a, n, wd, exp_a[i], exp_s[i]));
    end
    if (!wr)
      chk(rsp_rdata == exp_read(a, n), "R5", "assembled read operand", rsp_rdata, exp_read(a, n));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R5", "completion lasts one cycle", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R7", "ready back after last acknowledge", 32'(req_ready), 32'd1);
    if (!wr)
      chk(rsp_rdata == exp_read(a, n), "R5", "read operand held", rsp_rdata, exp_read(a, n));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1 && bus_ts == 1'b0 && rsp_valid == 1'b0 && fetch_err == 1'b0,
        "R9", "reset state", {28'd0, req_ready, bus_ts, rsp_valid, fetch_err}, 32'h8);

    // R1: aligned cases
    run_req(32'h0000_1000, 2'b00, 0, 0, 32'h0, 1);
    run_req(32'h0000_1000, 2'b00, 1, 0, 32'h1122_3344, 1);
    run_req(32'h0000_2002, 2'b10, 1, 0, 32'h0000_A1B2, 1);
    run_req(32'h0000_2003, 2'b01, 1, 0, 32'h0000_00C7, 1);
    run_req(32'h0000_2001, 2'b01, 0, 0, 32'h0, 1);
    // R2: misaligned longwords and words
    run_req(32'h0000_3001, 2'b00, 0, 0, 32'h0, 1);
    run_req(32'h0000_3001, 2'b00, 1, 0, 32'hA0B1_C2D3, 1);
    run_req(32'h0000_3002, 2'b00, 1, 0, 32'h5566_7788, 0);
    run_req(32'h0000_3003, 2'b00, 0, 0, 32'h0, 0);
    run_req(32'h0000_3003, 2'b10, 1, 0, 32'h0000_9ABC, 1);
    run_req(32'h0000_3001, 2'b10, 0, 0, 32'h0, 1);
    run_req(32'hFFFF_FFFE, 2'b00, 0, 0, 32'h0, 1);
    // R3: reserved size code behaves as a longword
    run_req(32'h0000_4001, 2'b11, 1, 0, 32'hCAFE_F00D, 1);
    // R8: fetches
    run_req(32'h0000_5003, 2'b10, 0, 1, 32'h0, 1);
    run_req(32'h0000_5001, 2'b00, 0, 1, 32'h0, 1);
    run_req(32'h0000_5002, 2'b00, 0, 1, 32'h0, 1);

    // R9: reset in the middle of a transfer
    @(negedge clk);
    req_addr = 32'h0000_6001; req_size = 2'b00; req_write = 1'b0; req_fetch = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_ts == 1'b1, "R9", "transfer started before reset", 32'(bus_ts), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1 && bus_ts == 1'b0 && rsp_valid == 1'b0,
        "R9", "idle after mid-transfer reset", {29'd0, req_ready, bus_ts, rsp_valid}, 32'h4);
    @(negedge clk);
    chk(bus_ts == 1'b0, "R9", "no strobe after reset", 32'(bus_ts), 32'd0);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a  = $urandom;
      logic [1:0]  sz = 2'($urandom);
      bit          wr = 1'($urandom);
      bit          fe = (($urandom % 8) == 0);
      run_req(a, sz, fe ? 1'b0 : wr, fe, $urandom, 1);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule